// File: doc/BRIEF.md
# DMA Command-Port Register Front End

This block is the 8-bit I/O register front end for a pair of four-channel DMA controller groups. The low group serves channels 0 to 3 and the high group serves channels 4 to 7. Each channel has a 16-bit base address register and a 16-bit word count register. Software reaches every such register through a single 8-bit port. The block keeps one byte-pointer flip-flop per group, which decides whether the next access lands on the lower or the upper byte.

Three write-only command ports per group act on the group when written, and the data byte is ignored. One clears the byte pointer. One performs a master clear, which has the same effect as the reset input. One unmasks all four channels of the group. The block presents the channel mask bits and all stored register values on parallel outputs for the transfer engine, which lies outside this block.

Top module: `dma_port_regs`

## Requirements
- R1: Any write to port 0x0C clears the low group's byte pointer, and any write to port 0xD8 clears the high group's byte pointer. The value written has no effect on the result.
- R2: Low group map: channel n's base address is at port 2n and its word count is at port 2n+1. Every read or write of one of these ports toggles the low byte pointer. The lower byte (bits 7:0) is taken first after a clear, then the upper byte (bits 15:8).
- R3: High group map: channel n (4 to 7, local index k = n-4) has its base address at port 0xC0+4k and its word count at port 0xC2+4k. These ports follow the same byte-pointer toggle and byte order as R2, using the high group's own pointer.
- R4: While rst is high at a clock edge, both byte pointers clear and all eight mask bits are set. In chan_mask_o, bit n is the mask of channel n, and 1 means masked. io_rdata resets to 0x00.
- R5: Any write to port 0x0D (low group) or 0xDA (high group) has the same effect on that group as reset: its pointer clears and its four mask bits are set. The value written has no effect on the result.
- R6: Any write to port 0x0E (low group) or 0xDC (high group) clears all four mask bits of that group.
- R7: A read of a 16-bit register port returns the byte selected by the pointer on io_rdata, registered and valid from the clock edge that samples io_rd. io_rdata holds its value until the next read.
- R8: A read of any port that is not a 16-bit register port returns 0x00. This includes the command ports. Such a read changes neither pointer nor any mask bit.
- R9: The two groups are independent. A register access or a command on one group leaves the other group's pointer, mask bits and registers unchanged.
- R10: When io_wr and io_rd are both high in the same cycle, the cycle acts as a write only, and io_rdata keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe, one access per cycle high |
| io_rd | input | 1 | Read strobe, one access per cycle high |
| io_rdata | output | 8 | Registered read data |
| chan_mask_o | output | 8 | Channel mask bits, bit n = channel n, 1 = masked |
| base_addr_o | output | 128 | Base address registers, channel n at bits [16n+15:16n] |
| word_cnt_o | output | 128 | Word count registers, channel n at bits [16n+15:16n] |

## Verification
The embedded assertions check the pointer and mask state on every cycle. They confirm that each register access flips the pointer and that each command lands one cycle later. They also confirm that a group nobody addressed keeps its pointer and masks, and that a read of a non-register port yields zero while a combined strobe leaves io_rdata alone. Byte steering into the right channel and register, and the lower-then-upper ordering seen from the ports, are shown only by the bench's directed scenarios. The same holds for pointer recovery after a mid-sequence clear and for the two different port maps. These scenarios compare assembled 16-bit values against expectations derived from the port maps.

// File: rtl/dma_port_pkg.sv
package dma_port_pkg;
  localparam int CH_PER_GRP = 4;
  localparam int CH_W       = $clog2(CH_PER_GRP);
  localparam int REG_W      = 16;
  localparam int BYTE_W     = 8;

  typedef struct packed {
    logic            reg_hit;   // address is a 16-bit register port of this group
    logic [CH_W-1:0] chan;      // local channel index
    logic            is_cnt;    // 1: word count, 0: base address
    logic            clr_ptr;   // clear byte pointer command port
    logic            mclr;      // master clear command port
    logic            clr_mask;  // clear mask command port
  } grp_dec_t;
endpackage

// File: rtl/dma_grp_decode.sv
module dma_grp_decode
  import dma_port_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_BASE  = 0,
  parameter int SHIFT     = 0,   // 0: ports packed, 1: even ports only
  parameter int P_CLRPTR  = 'h0C,
  parameter int P_MCLR    = 'h0D,
  parameter int P_CLRMASK = 'h0E
) (
  input  logic [ADDR_W-1:0] io_addr,
  output grp_dec_t          dec
);
  localparam int SPAN = (2 * CH_PER_GRP) << SHIFT;
  localparam logic [ADDR_W-1:0] BASE_V  = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] SPAN_V  = ADDR_W'(SPAN);
  localparam logic [ADDR_W-1:0] ALIGN_M = ADDR_W'((1 << SHIFT) - 1);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] idx;

  always_comb begin
    off          = io_addr - BASE_V;
    idx          = off >> SHIFT;
    dec.reg_hit  = (io_addr >= BASE_V) && (off < SPAN_V) && ((off & ALIGN_M) == '0);
    dec.chan     = idx[CH_W:1];
    dec.is_cnt   = idx[0];
    dec.clr_ptr  = (io_addr == ADDR_W'(P_CLRPTR));
    dec.mclr     = (io_addr == ADDR_W'(P_MCLR));
    dec.clr_mask = (io_addr == ADDR_W'(P_CLRMASK));
  end
endmodule

// File: rtl/dma_grp_regs.sv
module dma_grp_regs
  import dma_port_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic                       rd,
  input  logic [BYTE_W-1:0]          wdata,
  input  grp_dec_t                   dec,
  output logic [BYTE_W-1:0]          rd_byte,
  output logic [CH_PER_GRP-1:0]      mask_o,
  output logic [CH_PER_GRP*REG_W-1:0] base_o,
  output logic [CH_PER_GRP*REG_W-1:0] cnt_o
);
  logic                  ptr_q;
  logic [CH_PER_GRP-1:0] mask_q;
  logic [REG_W-1:0]      base_q [CH_PER_GRP];
  logic [REG_W-1:0]      cnt_q  [CH_PER_GRP];
  logic                  reg_acc;
  logic                  do_mclr;
  logic [REG_W-1:0]      sel_reg;

  assign reg_acc = dec.reg_hit && (wr || rd);
  assign do_mclr = wr && dec.mclr;

  // byte pointer flip-flop
  always_ff @(posedge clk) begin
    if (rst || do_mclr)               ptr_q <= 1'b0;
    else if (wr && dec.clr_ptr)       ptr_q <= 1'b0;
    else if (reg_acc)                 ptr_q <= ~ptr_q;
  end

  // channel mask bits
  always_ff @(posedge clk) begin
    if (rst || do_mclr)               mask_q <= '1;
    else if (wr && dec.clr_mask)      mask_q <= '0;
  end

  // 16-bit registers, contents undefined until written, no reset
  always_ff @(posedge clk) begin
    if (wr && dec.reg_hit) begin
      if (dec.is_cnt) begin
        if (ptr_q) cnt_q[dec.chan][15:8]  <= wdata;
        else       cnt_q[dec.chan][7:0]   <= wdata;
      end else begin
        if (ptr_q) base_q[dec.chan][15:8] <= wdata;
        else       base_q[dec.chan][7:0]  <= wdata;
      end
    end
  end

  always_comb begin
    sel_reg = dec.is_cnt ? cnt_q[dec.chan] : base_q[dec.chan];
    rd_byte = ptr_q ? sel_reg[15:8] : sel_reg[7:0];
  end

  assign mask_o = mask_q;

  for (genvar c = 0; c < CH_PER_GRP; c++) begin : g_flat
    assign base_o[c*REG_W +: REG_W] = base_q[c];
    assign cnt_o[c*REG_W +: REG_W]  = cnt_q[c];
  end

  // ---------------- assertions ----------------
  assert_reset_R4: assert property (@(posedge clk)
    rst |=> (ptr_q == 1'b0) && (mask_q == '1));

  assert_clr_ptr_R1: assert property (@(posedge clk) disable iff (rst)
    (wr && dec.clr_ptr) |=> (ptr_q == 1'b0));

  assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (dec.reg_hit && (wr || rd)) |=> (ptr_q != $past(ptr_q)));

  assert_mclr_R5: assert property (@(posedge clk) disable iff (rst)
    (wr && dec.mclr) |=> (ptr_q == 1'b0) && (mask_q == '1));

  assert_clr_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (wr && dec.clr_mask) |=> (mask_q == '0));

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !((wr || rd) && (dec.reg_hit || dec.clr_ptr || dec.mclr || dec.clr_mask))
      |=> $stable(ptr_q) && $stable(mask_q));

  assert_cmd_read_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr && !dec.reg_hit) |=> $stable(ptr_q) && $stable(mask_q));
endmodule

// File: rtl/dma_port_regs.sv
module dma_port_regs
  import dma_port_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int LO_REG_BASE  = 'h00,
  parameter int LO_CLRPTR    = 'h0C,
  parameter int LO_MCLR      = 'h0D,
  parameter int LO_CLRMASK   = 'h0E,
  parameter int HI_REG_BASE  = 'hC0,
  parameter int HI_CLRPTR    = 'hD8,
  parameter int HI_MCLR      = 'hDA,
  parameter int HI_CLRMASK   = 'hDC
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               io_addr,
  input  logic [BYTE_W-1:0]               io_wdata,
  input  logic                            io_wr,
  input  logic                            io_rd,
  output logic [BYTE_W-1:0]               io_rdata,
  output logic [2*CH_PER_GRP-1:0]         chan_mask_o,
  output logic [2*CH_PER_GRP*REG_W-1:0]   base_addr_o,
  output logic [2*CH_PER_GRP*REG_W-1:0]   word_cnt_o
);
  localparam int NGRP  = 2;
  localparam int GBITS = CH_PER_GRP * REG_W;

  grp_dec_t          dec_g  [NGRP];
  logic [BYTE_W-1:0] byte_g [NGRP];
  logic              any_hit;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int BASE = (g == 0) ? LO_REG_BASE : HI_REG_BASE;
    localparam int SH   = (g == 0) ? 0 : 1;
    localparam int PCP  = (g == 0) ? LO_CLRPTR  : HI_CLRPTR;
    localparam int PMC  = (g == 0) ? LO_MCLR    : HI_MCLR;
    localparam int PCM  = (g == 0) ? LO_CLRMASK : HI_CLRMASK;

    dma_grp_decode #(
      .ADDR_W(ADDR_W), .REG_BASE(BASE), .SHIFT(SH),
      .P_CLRPTR(PCP), .P_MCLR(PMC), .P_CLRMASK(PCM)
    ) u_dec (
      .io_addr (io_addr),
      .dec     (dec_g[g])
    );

    dma_grp_regs u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr      (io_wr),
      .rd      (io_rd),
      .wdata   (io_wdata),
      .dec     (dec_g[g]),
      .rd_byte (byte_g[g]),
      .mask_o  (chan_mask_o[g*CH_PER_GRP +: CH_PER_GRP]),
      .base_o  (base_addr_o[g*GBITS +: GBITS]),
      .cnt_o   (word_cnt_o[g*GBITS +: GBITS])
    );
  end

  assign any_hit = dec_g[0].reg_hit || dec_g[1].reg_hit;

  // registered read data; write wins over a simultaneous read
  always_ff @(posedge clk) begin
    if (rst)                        io_rdata <= '0;
    else if (io_rd && !io_wr) begin
      if (dec_g[0].reg_hit)         io_rdata <= byte_g[0];
      else if (dec_g[1].reg_hit)    io_rdata <= byte_g[1];
      else                          io_rdata <= '0;
    end
  end

  assert_rdata_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_wr && !any_hit) |=> (io_rdata == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    io_wr |=> $stable(io_rdata));
endmodule

// File: tb/dma_port_regs_test.sv
module dma_port_regs_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [7:0]   io_addr;
  logic [7:0]   io_wdata;
  logic         io_wr;
  logic         io_rd;
  logic [7:0]   io_rdata;
  logic [7:0]   chan_mask_o;
  logic [127:0] base_addr_o;
  logic [127:0] word_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_port_regs uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .chan_mask_o(chan_mask_o), .base_addr_o(base_addr_o), .word_cnt_o(word_cnt_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] base_of(int ch);
    return base_addr_o[ch*16 +: 16];
  endfunction

  function automatic logic [15:0] cnt_of(int ch);
    return word_cnt_o[ch*16 +: 16];
  endfunction

  task automatic io_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic t_reset();
    chk("R4 mask after reset", chan_mask_o, 8'hFF);
    chk("R4 rdata after reset", io_rdata, 8'h00);
  endtask

  task automatic t_low_map();
    io_write(8'h0C, 8'hA5);
    io_write(8'h00, 8'h34); io_write(8'h00, 8'h12);
    chk("R2 ch0 base", base_of(0), 16'h1234);
    io_write(8'h05, 8'h78); io_write(8'h05, 8'h56);
    chk("R2 ch2 count", cnt_of(2), 16'h5678);
    io_write(8'h06, 8'hCD); io_write(8'h06, 8'hAB);
    chk("R2 ch3 base", base_of(3), 16'hABCD);
  endtask

  task automatic t_high_map();
    io_write(8'hD8, 8'h00);
    io_write(8'hC4, 8'hBB); io_write(8'hC4, 8'hAA);
    chk("R3 ch5 base", base_of(5), 16'hAABB);
    io_write(8'hCE, 8'h22); io_write(8'hCE, 8'h11);
    chk("R3 ch7 count", cnt_of(7), 16'h1122);
    chk("R9 low ch3 base untouched", base_of(3), 16'hABCD);
  endtask

  task automatic t_clr_ptr_mid();
    io_write(8'h02, 8'h11);          // low ptr now upper
    io_write(8'h0C, 8'hFF);          // clear regardless of data
    io_write(8'h02, 8'h22); io_write(8'h02, 8'h33);
    chk("R1 low clear mid-sequence", base_of(1), 16'h3322);
    io_write(8'hC8, 8'h44);
    io_write(8'hD8, 8'h5A);
    io_write(8'hC8, 8'h66); io_write(8'hC8, 8'h77);
    chk("R1 high clear mid-sequence", base_of(6), 16'h7766);
  endtask

  task automatic t_read();
    logic [7:0] d;
    io_write(8'h0C, 8'h00);
    io_read(8'h00, d); chk("R7 read low byte", d, 8'h34);
    io_read(8'h00, d); chk("R7 read high byte", d, 8'h12);
    io_read(8'hC4, d); chk("R7 high group read low byte", d, 8'hBB);
  endtask

  task automatic t_cmd_read();
    logic [7:0] d;
    io_write(8'h0C, 8'h00);
    io_write(8'h07, 8'h9A);          // low ptr -> upper
    io_read(8'h0C, d); chk("R8 command port reads zero", d, 8'h00);
    io_read(8'h0E, d); chk("R8 read clear-mask port zero", d, 8'h00);
    chk("R8 read does not unmask", chan_mask_o, 8'hFF);
    io_write(8'h07, 8'hBC);
    chk("R8 pointer unchanged by reads", cnt_of(3), 16'hBC9A);
  endtask

  task automatic t_clr_mask();
    io_write(8'h0E, 8'h3C);
    chk("R6 low unmask", chan_mask_o, 8'hF0);
    io_write(8'hDC, 8'h00);
    chk("R6 high unmask", chan_mask_o, 8'h00);
  endtask

  task automatic t_master();
    io_write(8'hD8, 8'h00);
    io_write(8'hC0, 8'h01);          // high ptr -> upper
    io_write(8'h0C, 8'h00);
    io_write(8'h01, 8'hEE);          // low ptr -> upper
    io_write(8'h0D, 8'h77);
    chk("R5 low master clear masks", chan_mask_o, 8'h0F);
    io_write(8'h01, 8'h10); io_write(8'h01, 8'h20);
    chk("R5 low pointer cleared", cnt_of(0), 16'h2010);
    io_write(8'hC0, 8'h02);
    chk("R9 high pointer kept", base_of(4), 16'h0201);
    io_write(8'hDA, 8'h00);
    chk("R5 high master clear masks", chan_mask_o, 8'hFF);
  endtask

  task automatic t_both();
    logic [7:0] d;
    io_write(8'h0C, 8'h00);
    io_read(8'h00, d);               // rdata = 0x34, ptr -> upper
    @(negedge clk);
    io_addr = 8'h00; io_wdata = 8'h99; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    chk("R10 rdata held", io_rdata, 8'h34);
    chk("R10 acted as write", base_of(0), 16'h9934);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; io_addr = '0; io_wdata = '0; io_wr = 1'b0; io_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_low_map();
    t_high_map();
    t_clr_ptr_mid();
    t_read();
    t_cmd_read();
    t_clr_mask();
    t_master();
    t_both();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule